// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a three-wire serial memory link. A host raises chip select, clocks in a start bit, a two-bit opcode and an address on the serial input, and the block acts on the command. It supports a read, a word write and an extended command that arms or disarms programming. The storage is a small internal register array that stands in for non-volatile cells. It holds 2^ADDR_W bytes and is cleared by reset.

All logic runs on a fast system clock. The serial clock and chip select are sampled as ordinary inputs, and their rising and falling edges are found inside the block. An organisation input picks between byte-wide words and 16-bit words. A protection latch starts out disarmed and gates every write. Reads ignore that latch. A read sends a dummy zero first, then the word most significant bit first. If chip select stays high, the read continues into the following words.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the protection latch is disarmed, and a write command leaves the array unchanged.
- R2: An extended command (opcode 00) whose two top address bits are 11 arms the latch. A later write then updates the array.
- R3: The latch stays armed through any number of commands until an extended command with top address bits 00 disarms it, or reset clears it. A write while disarmed changes nothing.
- R4: A read returns the stored word whether the latch is armed or disarmed.
- R5: After the last address bit of a read, the output first carries one dummy 0 bit, and only then the word's data bits.
- R6: With orgWide low, words are 8 bits and addresses are 8 bits. With orgWide high, words are 16 bits and addresses are 7 bits. Word a is then byte 2a as the high half and byte 2a+1 as the low half.
- R7: Serial input is sampled on the rising serial clock edge, MSB first. The output changes only just after a rising serial clock edge.
- R8: While chip select stays high after a word has been sent, the next word (address plus one, wrapping at the top) follows with no further dummy bit.
- R9: A command is a start bit 1, then a 2-bit opcode (10 read, 01 write, 00 extended), then the address, then for a write the data word MSB first. Zeros before the start bit are ignored.
- R10: While chip select is low, sdoEn is 0 and the decoder returns to waiting for a start bit, so a partial command is dropped.
- R11: A write takes effect when chip select falls, and only if the latch is armed and every data bit was received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| orgWide | input | 1 | 0: 8-bit words, 1: 16-bit words |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output enable; 0 means high impedance |

## Verification
Every cycle, the assertions check the following:
- the output enable stays off while chip select is low;
- a read always starts with a dummy zero;
- the output only changes on the cycle after a serial clock rise;
- the protection latch is clear when reset lifts and moves only while chip select is high.

The bench's scenarios are needed for the rest, because those behaviours show only in array contents read back later:
- that a write is dropped or kept depending on the latch;
- that a truncated write is lost;
- the byte order of 16-bit words;
- sequential reads that wrap past the top address.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADR, S_WDAT, S_RD, S_HOLD
  } mwState_t;

  typedef struct packed {
    logic bitIn;
    logic shiftAddr;
    logic shiftData;
    logic loadRead;
    logic shiftOut;
    logic advance;
    logic extCmd;
    logic commit;
  } mwStrobe_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csel,
  input  logic      sclk,
  input  logic      sdi,
  input  logic      orgWide,
  output mwStrobe_t stb,
  output logic      readActive
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(WIDE_W + 1);

  mwState_t st, stNext;
  logic [CNT_W-1:0] cnt, cntNext, addrLen, wordLen;
  logic [1:0] opReg, opNext;
  logic armed, armNext, sclkQ, cselQ, rise, csFall;

  assign rise    = sclk & ~sclkQ;
  assign csFall  = cselQ & ~csel;
  assign addrLen = orgWide ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
  assign wordLen = orgWide ? CNT_W'(WIDE_W) : CNT_W'(BYTE_W);
  assign readActive = csel && (st == S_RD);

  always_comb begin
    stb       = '0;
    stb.bitIn = sdi;
    stb.commit = csFall && armed;
    stNext  = st;
    cntNext = cnt;
    opNext  = opReg;
    armNext = armed;
    if (!csel) begin
      stNext  = S_IDLE;
      cntNext = '0;
      armNext = 1'b0;
    end else if (rise) begin
      case (st)
        S_IDLE: if (sdi) begin
          stNext  = S_OPC;
          cntNext = '0;
          opNext  = 2'b00;
        end
        S_OPC: begin
          opNext = {opReg[0], sdi};
          if (cnt == CNT_W'(1)) begin
            stNext  = S_ADR;
            cntNext = '0;
          end else cntNext = cnt + 1'b1;
        end
        S_ADR: begin
          stb.shiftAddr = 1'b1;
          if (cnt == addrLen - 1'b1) begin
            cntNext = '0;
            case (opReg)
              OP_READ: begin
                stb.loadRead = 1'b1;
                stNext = S_RD;
              end
              OP_WRITE: stNext = S_WDAT;
              OP_EXT: begin
                stb.extCmd = 1'b1;
                stNext = S_HOLD;
              end
              default: stNext = S_HOLD;
            endcase
          end else cntNext = cnt + 1'b1;
        end
        S_WDAT: begin
          stb.shiftData = 1'b1;
          if (cnt == wordLen - 1'b1) begin
            stNext  = S_HOLD;
            armNext = 1'b1;
          end else cntNext = cnt + 1'b1;
        end
        S_RD: begin
          if (cnt == wordLen) begin
            stb.advance = 1'b1;
            cntNext = CNT_W'(1);
          end else begin
            stb.shiftOut = 1'b1;
            cntNext = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      cnt   <= '0;
      opReg <= 2'b00;
      armed <= 1'b0;
      sclkQ <= 1'b0;
      cselQ <= 1'b0;
    end else begin
      st    <= stNext;
      cnt   <= cntNext;
      opReg <= opNext;
      armed <= armNext;
      sclkQ <= sclk;
      cselQ <= csel;
    end
  end
endmodule

// File: rtl/mw_dpath.sv
module mw_dpath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      orgWide,
  input  mwStrobe_t stb,
  output logic      sdo,
  output logic      writeEn
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg, addrNext, addrInc, wordMask;
  logic [WIDE_W-1:0] dataReg, outSh, loadWord, incWord;
  logic [1:0] extTop;

  assign wordMask = orgWide ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};
  assign addrNext = {addrReg[ADDR_W-2:0], stb.bitIn} & wordMask;
  assign addrInc  = (addrReg + 1'b1) & wordMask;
  assign extTop   = orgWide ? addrNext[ADDR_W-2 -: 2] : addrNext[ADDR_W-1 -: 2];

  function automatic logic [WIDE_W-1:0] fetch(input logic [ADDR_W-1:0] a, input logic wide);
    if (wide)
      return {mem[{a[ADDR_W-2:0], 1'b0}], mem[{a[ADDR_W-2:0], 1'b1}]};
    else
      return {mem[a], {BYTE_W{1'b0}}};
  endfunction

  assign loadWord = fetch(addrNext, orgWide);
  assign incWord  = fetch(addrInc, orgWide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      outSh   <= '0;
      sdo     <= 1'b0;
      writeEn <= 1'b0;
    end else begin
      if (stb.loadRead) begin
        addrReg <= addrNext;
        outSh   <= loadWord;
        sdo     <= 1'b0;
      end else if (stb.shiftAddr) begin
        addrReg <= addrNext;
      end else if (stb.advance) begin
        addrReg <= addrInc;
        sdo     <= incWord[WIDE_W-1];
        outSh   <= incWord << 1;
      end else if (stb.shiftOut) begin
        sdo   <= outSh[WIDE_W-1];
        outSh <= outSh << 1;
      end
      if (stb.shiftData) dataReg <= {dataReg[WIDE_W-2:0], stb.bitIn};
      if (stb.extCmd) begin
        if (extTop == 2'b11) writeEn <= 1'b1;
        else if (extTop == 2'b00) writeEn <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit && writeEn) begin
      if (orgWide) begin
        mem[{addrReg[ADDR_W-2:0], 1'b0}] <= dataReg[WIDE_W-1:BYTE_W];
        mem[{addrReg[ADDR_W-2:0], 1'b1}] <= dataReg[BYTE_W-1:0];
      end else begin
        mem[addrReg] <= dataReg[BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic csel,
  input  logic sclk,
  input  logic sdi,
  input  logic orgWide,
  output logic sdo,
  output logic sdoEn
);
  mwStrobe_t stb;
  logic readActive;
  logic writeEn;

  mw_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .sdi(sdi),
    .orgWide(orgWide), .stb(stb), .readActive(readActive)
  );

  mw_dpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .stb(stb),
    .sdo(sdo), .writeEn(writeEn)
  );

  assign sdoEn = readActive;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rstN,
  input logic csel,
  input logic sclk,
  input logic sdo,
  input logic sdoEn,
  input logic writeEn
);
  // R1
  latch_clear_at_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !writeEn);

  // R3
  latch_arm_in_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeEn) |-> $past(csel));

  // R3
  latch_disarm_in_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeEn) |-> $past(csel));

  // R10
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csel |-> !sdoEn);

  // R5
  dummy_zero_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> !sdo);

  // R7
  out_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && !$stable(sdo)) |-> ($past(sclk) && !$past(sclk, 2)));
endmodule

bind mw_eeprom_slave mw_eeprom_chk u_chk (
  .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk),
  .sdo(sdo), .sdoEn(sdoEn), .writeEn(writeEn)
);

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rstN = 1'b0, csel = 1'b0, sclk = 1'b0, sdi = 1'b0, orgWide = 1'b0;
  logic sdo, sdoEn;
  int total = 0, bad = 0;
  logic [7:0] model [DEPTH];
  logic modelEn = 1'b0;
  bit finished = 1'b0;

  mw_eeprom_slave #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .sdi(sdi),
    .orgWide(orgWide), .sdo(sdo), .sdoEn(sdoEn)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int expWord(input int a, input bit wide);
    if (wide) return {model[(a % 128) * 2], model[(a % 128) * 2 + 1]};
    return int'(model[a % DEPTH]);
  endfunction

  task automatic pulse();
    @(negedge clk) sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdi = v[i];
      pulse();
    end
  endtask

  task automatic csDrop();
    @(negedge clk) csel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csRaise();
    @(negedge clk) csel = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic extCmd(input bit arm);
    int aw = orgWide ? 7 : 8;
    csRaise();
    sendBits(16'b100, 3);
    sendBits(arm ? (16'b11 << (aw - 2)) : 16'h0, aw);
    csDrop();
    modelEn = arm;
  endtask

  task automatic writeCmd(input int a, input int d);
    int aw = orgWide ? 7 : 8;
    int ww = orgWide ? 16 : 8;
    csRaise();
    sendBits(16'b101, 3);
    sendBits(16'(a), aw);
    sendBits(16'(d), ww);
    csDrop();
    if (modelEn) begin
      if (orgWide) begin
        model[(a % 128) * 2]     = 8'(d >> 8);
        model[(a % 128) * 2 + 1] = 8'(d);
      end else model[a % DEPTH] = 8'(d);
    end
  endtask

  task automatic readCmd(input int a, input int n, input string tag, input bit chkStable);
    int aw = orgWide ? 7 : 8;
    int ww = orgWide ? 16 : 8;
    int span = orgWide ? 128 : DEPTH;
    csRaise();
    sendBits(16'b110, 3);
    sendBits(16'(a), aw);
    check(sdoEn === 1'b1, "R9 read enables output", int'(sdoEn), 1);
    check(sdo === 1'b0, "R5 dummy zero", int'(sdo), 0);
    for (int k = 0; k < n; k++) begin
      int got = 0;
      for (int b = 0; b < ww; b++) begin
        logic early;
        @(negedge clk) sclk = 1'b1;
        repeat (2) @(negedge clk);
        early = sdo;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        if (chkStable)
          check(sdo === early, "R7 output steady between rises", int'(sdo), int'(early));
        got = (got << 1) | int'(sdo);
      end
      check(got == expWord((a + k) % span, orgWide),
            k == 0 ? tag : "R8 sequential word", got, expWord((a + k) % span, orgWide));
    end
    csDrop();
    check(sdoEn === 1'b0, "R10 output off after deselect", int'(sdoEn), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    check(sdoEn === 1'b0, "R10 output off in reset", int'(sdoEn), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdoEn === 1'b0, "R10 output off after reset", int'(sdoEn), 0);

    // R1: write before arming is dropped
    orgWide = 1'b0;
    writeCmd(8'h12, 8'hA5);
    readCmd(8'h12, 1, "R1 write ignored after reset", 1'b1);

    // R9: leading zeros before the start bit, then arm
    csRaise();
    sendBits(16'b0, 3);
    sendBits(16'b100, 3);
    sendBits(16'hC0, 8);
    csDrop();
    modelEn = 1'b1;
    writeCmd(8'h12, 8'h5A);
    readCmd(8'h12, 1, "R2 write after arming", 1'b0);

    // R3: stays armed over several commands
    writeCmd(8'h13, 8'h3C);
    readCmd(8'h13, 1, "R3 still armed", 1'b0);

    // R11: truncated write is lost
    csRaise();
    sendBits(16'b101, 3);
    sendBits(16'h13, 8);
    sendBits(16'hF, 4);
    csDrop();
    readCmd(8'h13, 1, "R11 truncated write dropped", 1'b0);

    // R10: abort a read mid-address, next command decodes cleanly
    csRaise();
    sendBits(16'b110, 3);
    sendBits(16'h3, 3);
    csDrop();
    check(sdoEn === 1'b0, "R10 partial command dropped", int'(sdoEn), 0);
    readCmd(8'h12, 2, "R10 decoder restarted", 1'b0);

    // R8: wrap at the top address
    writeCmd(8'hFF, 8'h81);
    writeCmd(8'h00, 8'h7E);
    readCmd(8'hFF, 2, "R8 wrap first word", 1'b0);

    // R6: 16-bit organisation and byte order
    orgWide = 1'b1;
    writeCmd(7'h09, 16'hBEEF);
    readCmd(7'h09, 1, "R6 wide word", 1'b1);
    orgWide = 1'b0;
    readCmd(8'h12, 1, "R6 narrow address", 1'b0);
    readCmd(8'h13, 1, "R6 wide low byte at odd address", 1'b0);
    orgWide = 1'b1;
    readCmd(7'h7F, 2, "R8 wide wrap", 1'b0);

    // R3 / R4: disarm, write dropped, reads still work
    extCmd(1'b0);
    writeCmd(7'h09, 16'h1234);
    readCmd(7'h09, 1, "R4 read while disarmed", 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int op = $urandom_range(0, 5);
      orgWide = 1'($urandom_range(0, 1));
      case (op)
        0, 1: writeCmd($urandom_range(0, orgWide ? 127 : 255), $urandom_range(0, 65535));
        2, 3: readCmd($urandom_range(0, orgWide ? 127 : 255), $urandom_range(1, 3),
                      modelEn ? "R4 random read armed" : "R4 random read disarmed", 1'b0);
        4: extCmd(1'b1);
        default: extCmd(1'b0);
      endcase
    end

    // R1: reset disarms the latch
    extCmd(1'b1);
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    modelEn = 1'b0;
    orgWide = 1'b0;
    writeCmd(8'h40, 8'h99);
    readCmd(8'h40, 1, "R1 reset disarms", 1'b0);

    summary();
  end
endmodule